// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences one analog-to-digital conversion by binary search. It derives a slower converter clock from the bus clock. A start pulse begins a fixed two-tick sampling window, then a sampling window whose length is chosen by a two-bit code. After sampling, the block decides one result bit per converter tick, beginning at the most significant bit. On each tick it offers a trial code to an external DAC and reads back a comparator decision. When the least significant bit is decided, it publishes the code and raises a one-cycle completion pulse.

The DAC, comparator and sample-and-hold sit outside the block. A test path lets the trial register be loaded directly while the block is idle, which drives the DAC with any code. Clearing the enable input stops any conversion at once.

Top module: `sar_conv_engine`

## Requirements
- R1: After reset, `result` and `dac_code` are zero and `eoc` and `busy` are low.
- R2: One converter tick lasts 2*(`prs`+1) bus cycles. `prs` and `smp` are captured on the cycle that `start` is accepted.
- R3: Sampling is 2 ticks, followed by a programmable window set by `smp`: 00=2, 01=4, 10=8, 11=16 ticks.
- R4: `eoc` is high on exactly the cycle 2*(`prs`+1)*(2+S+NBITS) bus cycles after the clock edge that accepts `start`. S is the programmable window from R3.
- R5: The comparator input is high when the sampled input is at or above `dac_code`. With that input, `result` equals the input code over the full range 0..2^NBITS-1.
- R6: `eoc` lasts one cycle and `busy` is low while it is high. `result` changes only on the cycle `eoc` goes high.
- R7: The first trial code after sampling has only the MSB set. Bits are then decided from the MSB down to the LSB.
- R8: While idle and enabled, `test_wr` with `test_mode` high loads `test_data` into the trial register, which shows on `dac_code` the next cycle. With `test_mode` low, `test_wr` has no effect on `dac_code`.
- R9: With `enable` low, `busy` drops on the next cycle, no `eoc` follows, `result` keeps its value, and `start` is ignored.
- R10: A `start` pulse during a conversion is ignored, so the conversion ends at its original time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Power-up enable; low aborts |
| start | input | 1 | Conversion request, one cycle |
| prs | input | PRS_W | Prescale value |
| smp | input | 2 | Programmable sample window code |
| cmp_ge | input | 1 | Comparator: input at or above DAC |
| test_mode | input | 1 | Allows direct trial-register load |
| test_wr | input | 1 | Trial-register load strobe |
| test_data | input | NBITS | Value for trial-register load |
| dac_code | output | NBITS | Trial code to DAC |
| result | output | NBITS | Last completed conversion |
| eoc | output | 1 | Conversion complete pulse |
| busy | output | 1 | Conversion in progress |

## Verification
A wrong prescaler or phase counter shows at the ports as `eoc` arriving early or late. The bench measures that delay to the exact bus cycle for every `smp` code and several `prs` values, so a one-count error shows on the first conversion. A wrong bit index or keep/clear decision gives a wrong `result` within one conversion; codes near zero, full scale and mid-scale expose it. The first trial code is also checked on the cycle it appears. A fault in abort or test-load handling shows as a stray `eoc`, a changed `result` or a `dac_code` that moves when it should not.

// File: rtl/sar_conv_engine.sv
module sar_conv_engine #(
  parameter int NBITS = 10,
  parameter int PRS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [PRS_W-1:0] prs,
  input  logic [1:0]       smp,
  input  logic             cmp_ge,
  input  logic             test_mode,
  input  logic             test_wr,
  input  logic [NBITS-1:0] test_data,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] result,
  output logic             eoc,
  output logic             busy
);
  localparam int BW = (NBITS > 2) ? $clog2(NBITS) : 1;
  localparam logic [BW-1:0] TOP = BW'(NBITS - 1);
  localparam logic [NBITS-1:0] ONE = NBITS'(1);

  typedef enum logic [1:0] {IDLE, SAMP, CONV} st_t;

  st_t              st;
  logic [PRS_W-1:0] pcnt, prs_q;
  logic             half;
  logic [1:0]       smp_q;
  logic [4:0]       scnt;
  logic [BW-1:0]    bidx;
  logic [NBITS-1:0] sar;

  wire             tick     = (st != IDLE) && (pcnt == prs_q) && half;
  wire [4:0]       samp_len = 5'd2 + (5'd2 << smp_q);
  wire [NBITS-1:0] mask     = ONE << bidx;
  wire [NBITS-1:0] kept     = cmp_ge ? sar : (sar & ~mask);
  wire [NBITS-1:0] next_sar = (bidx == '0) ? kept : (kept | (mask >> 1));

  assign dac_code = sar;
  assign busy     = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      pcnt   <= '0;
      prs_q  <= '0;
      half   <= 1'b0;
      smp_q  <= '0;
      scnt   <= '0;
      bidx   <= '0;
      sar    <= '0;
      result <= '0;
      eoc    <= 1'b0;
    end else begin
      eoc <= 1'b0;
      if (!enable) begin
        st   <= IDLE;
        pcnt <= '0;
        half <= 1'b0;
      end else if (st == IDLE) begin
        pcnt <= '0;
        half <= 1'b0;
        if (start) begin
          st    <= SAMP;
          prs_q <= prs;
          smp_q <= smp;
          scnt  <= '0;
        end else if (test_mode && test_wr) begin
          sar <= test_data;
        end
      end else begin
        if (pcnt == prs_q) begin
          pcnt <= '0;
          half <= ~half;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
        if (tick) begin
          if (st == SAMP) begin
            if (scnt == samp_len - 5'd1) begin
              st   <= CONV;
              sar  <= ONE << TOP;
              bidx <= TOP;
            end else begin
              scnt <= scnt + 5'd1;
            end
          end else begin
            sar <= next_sar;
            if (bidx == '0) begin
              result <= kept;
              eoc    <= 1'b1;
              st     <= IDLE;
            end else begin
              bidx <= bidx - 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_conv_engine_chk.sv
module sar_conv_engine_chk #(
  parameter int NBITS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             start,
  input logic             test_mode,
  input logic             test_wr,
  input logic [NBITS-1:0] dac_code,
  input logic [NBITS-1:0] result,
  input logic             eoc,
  input logic             busy
);
  p_eoc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);
  p_eoc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> !busy);
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> eoc);
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && enable));
  p_dac_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && !$past(test_mode && test_wr)) |-> $stable(dac_code));
endmodule

bind sar_conv_engine sar_conv_engine_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
  .test_mode(test_mode), .test_wr(test_wr), .dac_code(dac_code),
  .result(result), .eoc(eoc), .busy(busy)
);

// File: tb/tb_sar_conv_engine.sv
module tb_sar_conv_engine;
  localparam int N = 10;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, start = 1'b0;
  logic [4:0] prs = '0;
  logic [1:0] smp = '0;
  logic test_mode = 1'b0, test_wr = 1'b0;
  logic [N-1:0] test_data = '0, vin = '0;
  logic [N-1:0] dac_code, result;
  logic eoc, busy, cmp_ge;
  int checks = 0, errors = 0, cyc = 0;

  assign cmp_ge = (vin >= dac_code);

  sar_conv_engine #(.NBITS(N), .PRS_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .prs(prs),
    .smp(smp), .cmp_ge(cmp_ge), .test_mode(test_mode), .test_wr(test_wr),
    .test_data(test_data), .dac_code(dac_code), .result(result),
    .eoc(eoc), .busy(busy));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(result == 0 && dac_code == 0, "R1 data zero", int'(result | dac_code), 0);
    chk(!eoc && !busy, "R1 flags low", int'({eoc, busy}), 0);
  endtask

  // restart_at: cycle at which a second start pulse is issued (0 = none)
  task automatic t_convert(input int p, input int s, input int v, input int restart_at);
    int d, smpl, total, first, m, seen, prev;
    d = 2 * (p + 1);
    smpl = 2 << s;
    total = d * (2 + smpl + N);
    first = d * (2 + smpl);
    prev = int'(result);
    @(negedge clk);
    prs = 5'(p); smp = 2'(s); vin = N'(v); start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    prs = ~5'(p); smp = ~2'(s);
    m = 0; seen = 0;
    while (m < total + 5 && seen == 0) begin
      @(posedge clk); m++;
      if (m == restart_at) begin
        @(negedge clk); start = 1'b1;
        @(posedge clk); m++;
        #1 start = 1'b0;
      end else begin
        #1;
      end
      if (m == first)
        chk(dac_code == (N'(1) << (N - 1)), "R7 first trial MSB", int'(dac_code), 1 << (N - 1));
      if (m < total && eoc) begin
        chk(0, "R4 early eoc", m, total);
        seen = 1;
      end
      if (m < total)
        chk(int'(result) == prev, "R6 result held before eoc", int'(result), prev);
      if (m == total) begin
        chk(eoc == 1'b1, restart_at != 0 ? "R10 end time after restart" : "R4 R2 R3 eoc time", int'(eoc), 1);
        chk(int'(result) == v, "R5 result", int'(result), v);
        chk(!busy, "R6 idle at eoc", int'(busy), 0);
        seen = 1;
      end
    end
    @(posedge clk); #1;
    chk(!eoc, "R6 eoc one cycle", int'(eoc), 0);
  endtask

  task automatic t_test_write();
    @(negedge clk);
    test_mode = 1'b1; test_wr = 1'b1; test_data = N'(10'h2A5);
    @(negedge clk);
    test_wr = 1'b0;
    chk(dac_code == N'(10'h2A5), "R8 test load", int'(dac_code), 'h2A5);
    test_mode = 1'b0; test_wr = 1'b1; test_data = N'(10'h0F0);
    @(negedge clk);
    test_wr = 1'b0;
    chk(dac_code == N'(10'h2A5), "R8 load ignored without test mode", int'(dac_code), 'h2A5);
  endtask

  task automatic t_abort();
    int prev;
    prev = int'(result);
    @(negedge clk);
    prs = 5'd1; smp = 2'd0; vin = N'(777); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy, "R9 running before abort", int'(busy), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(!busy, "R9 busy drops", int'(busy), 0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!busy, "R9 start ignored when disabled", int'(busy), 0);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (eoc) chk(0, "R9 no eoc after abort", 1, 0);
    end
    chk(int'(result) == prev, "R9 result kept", int'(result), prev);
    enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; enable = 1'b1;
    repeat (2) @(negedge clk);
    t_convert(0, 0, 0, 0);
    t_convert(3, 0, 1023, 0);
    t_convert(1, 1, 512, 0);
    t_convert(0, 2, 511, 0);
    t_convert(2, 3, 341, 0);
    t_convert(31, 0, 1, 0);
    t_convert(0, 3, 682, 0);
    t_test_write();
    t_convert(1, 0, 100, 0);
    t_convert(1, 1, 900, 10);
    t_abort();
    t_convert(0, 1, 256, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule